// File: doc/BRIEF.md
# Four-Word Line Gathering Writer for Vertex Memory

This block is the write path from a register bus into an on-chip vertex memory whose lines are 128 bits wide. Software first programs a line address through the address register. The address is given in bytes, and its low four bits are dropped. Software then streams 32-bit words into the data register, one per bus write, and may issue those writes on consecutive cycles. The block packs the words into a 128-bit line. It writes memory only when a line is complete, as one wide write. After that write it moves its address to the next 16-byte line.

When fewer than four words have arrived, the block holds them and writes nothing. It waits for the missing words for as long as it takes. Writing the address register throws away any words that are held. A status register reports how many words are held. The address register reads back the address the next line will use, so software can follow the automatic advance.

The gather control is a four-state machine named after the number of held words. The states are `GATHER_EMPTY`, `GATHER_ONE`, `GATHER_TWO` and `GATHER_THREE`. A data write moves the machine one state forward (EMPTY→ONE→TWO→THREE). A data write in `GATHER_THREE` is the *commit* transition, which goes back to `GATHER_EMPTY` and starts the memory write. An address write is the *flush* transition, which goes from any state to `GATHER_EMPTY`. With no write, the machine stays in its state.

Top module: `vlw_line_writer`

## Requirements
- R1: After reset the address register reads 0, the held-word count reads 0 and `mem_we` is low.
- R2: A write with `bus_sel`=0 loads the line address from `bus_wdata[LINE_AW+3:4]`. Reading `bus_sel`=0 returns that line number placed at bit 4 upward, with bits 3:0 and every bit above `LINE_AW+3` read as 0.
- R3: Reading `bus_sel`=2 returns the held-word count (0 to 3) in bits 1:0 and 0 in all other bits. Each write with `bus_sel`=1 raises the count by one until it reaches 3.
- R4: With fewer than four words gathered, `mem_we` stays low. The held words and their count are kept for any number of idle cycles.
- R5: The fourth data write raises `mem_we` for exactly one cycle, the cycle after that write. `mem_addr` then carries the line address in force during the first to fourth words. `mem_wdata` carries the first word in bits 31:0, the second in 63:32, the third in 95:64 and the fourth in 127:96.
- R6: In the same cycle that `mem_we` is high, the address register already reads 16 bytes higher and the held-word count reads 0.
- R7: The line address wraps from `2**LINE_AW-1` to 0 after a commit.
- R8: Data writes on consecutive cycles are all accepted, and every fourth one produces a commit.
- R9: Writes with `bus_sel`=2 or 3 change no state. Reads with `bus_sel`=1 or 3 return 0.
- R10: An address write drops the held words. The next line committed holds only words written after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_en | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_sel | input | 2 | Register select: 0 address, 1 data, 2 status, 3 spare |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_sel` |
| mem_we | output | 1 | Memory line write strobe |
| mem_addr | output | LINE_AW | Memory line index |
| mem_wdata | output | 128 | Memory line data |

## Verification
A line commit and the next bus write can meet in one cycle. While `mem_we` is high for a finished line, the bus may already be delivering the first word of the next line or a new address. The bench provokes this with unbroken bursts of data writes and with address writes placed right after a fourth word. Every cycle it compares `mem_we`, `mem_addr` and `mem_wdata` with a bench model. The model must show that the committed line keeps its old address and words while the held-word count and address move on for the new traffic.

// File: rtl/vlw_pkg.sv
package vlw_pkg;

    localparam int unsigned WORD_W         = 32;
    localparam int unsigned WORDS_PER_LINE = 4;
    localparam int unsigned LINE_W         = WORD_W * WORDS_PER_LINE;
    localparam int unsigned CNT_W          = $clog2(WORDS_PER_LINE);

    // state encoding equals the number of held words
    typedef enum logic [CNT_W-1:0] {
        GATHER_EMPTY = 2'd0,
        GATHER_ONE   = 2'd1,
        GATHER_TWO   = 2'd2,
        GATHER_THREE = 2'd3
    } gather_state_t;

    typedef enum logic [1:0] {
        SEL_ADDR   = 2'd0,
        SEL_DATA   = 2'd1,
        SEL_STATUS = 2'd2,
        SEL_SPARE  = 2'd3
    } reg_sel_t;

endpackage

// File: rtl/vlw_line_addr.sv
module vlw_line_addr #(
    parameter int unsigned LINE_AW = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [LINE_AW-1:0] load_line,
    input  logic               advance,
    output logic [LINE_AW-1:0] line_q
);

    // line count is a power of two, so the increment wraps to zero
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= '0;
        end else if (load) begin
            line_q <= load_line;
        end else if (advance) begin
            line_q <= line_q + LINE_AW'(1);
        end
    end

endmodule

// File: rtl/vlw_gather.sv
module vlw_gather
    import vlw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_wr,
    input  logic              flush,
    input  logic [WORD_W-1:0] word_in,
    output logic              line_done,
    output logic [LINE_W-1:0] line_data,
    output logic [CNT_W-1:0]  pending
);

    gather_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GATHER_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d   = state_q;
        line_done = 1'b0;
        if (flush) begin
            state_d = GATHER_EMPTY;
        end else if (word_wr) begin
            unique case (state_q)
                GATHER_EMPTY: state_d = GATHER_ONE;
                GATHER_ONE:   state_d = GATHER_TWO;
                GATHER_TWO:   state_d = GATHER_THREE;
                GATHER_THREE: begin
                    state_d   = GATHER_EMPTY;
                    line_done = 1'b1;
                end
            endcase
        end
    end

    assign pending = state_q;

    // holding slots for the first three words; the last comes straight from the bus
    for (genvar g = 0; g < WORDS_PER_LINE - 1; g++) begin : g_slot
        logic [WORD_W-1:0] slot_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (word_wr && !flush && (state_q == gather_state_t'(CNT_W'(g)))) begin
                slot_q <= word_in;
            end
        end
        assign line_data[g*WORD_W +: WORD_W] = slot_q;
    end

    assign line_data[(WORDS_PER_LINE-1)*WORD_W +: WORD_W] = word_in;

endmodule

// File: rtl/vlw_commit.sv
module vlw_commit
    import vlw_pkg::*;
#(
    parameter int unsigned LINE_AW = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fire,
    input  logic [LINE_AW-1:0] line_in,
    input  logic [LINE_W-1:0]  data_in,
    output logic               mem_we,
    output logic [LINE_AW-1:0] mem_addr,
    output logic [LINE_W-1:0]  mem_wdata
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            mem_we <= fire;
            if (fire) begin
                mem_addr  <= line_in;
                mem_wdata <= data_in;
            end
        end
    end

endmodule

// File: rtl/vlw_line_writer.sv
module vlw_line_writer
    import vlw_pkg::*;
#(
    parameter int unsigned LINE_AW = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_en,
    input  logic               bus_we,
    input  logic [1:0]         bus_sel,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               mem_we,
    output logic [LINE_AW-1:0] mem_addr,
    output logic [127:0]       mem_wdata
);

    localparam int unsigned BYTE_AW = LINE_AW + 4;

    reg_sel_t             sel;
    logic                 addr_wr;
    logic                 data_wr;
    logic                 line_done;
    logic [LINE_W-1:0]    line_data;
    logic [CNT_W-1:0]     pend_cnt;
    logic [LINE_AW-1:0]   line_q;

    assign sel     = reg_sel_t'(bus_sel);
    assign addr_wr = bus_en && bus_we && (sel == SEL_ADDR);
    assign data_wr = bus_en && bus_we && (sel == SEL_DATA);

    vlw_line_addr #(.LINE_AW(LINE_AW)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (addr_wr),
        .load_line (bus_wdata[BYTE_AW-1:4]),
        .advance   (line_done),
        .line_q    (line_q)
    );

    vlw_gather u_gather (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_wr   (data_wr),
        .flush     (addr_wr),
        .word_in   (bus_wdata),
        .line_done (line_done),
        .line_data (line_data),
        .pending   (pend_cnt)
    );

    vlw_commit #(.LINE_AW(LINE_AW)) u_commit (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (line_done),
        .line_in   (line_q),
        .data_in   (line_data),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            SEL_ADDR:   bus_rdata[BYTE_AW-1:4] = line_q;
            SEL_STATUS: bus_rdata[CNT_W-1:0]   = pend_cnt;
            SEL_DATA,
            SEL_SPARE:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/vlw_line_writer_chk.sv
module vlw_line_writer_chk #(
    parameter int unsigned LINE_AW = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               addr_wr,
    input logic               data_wr,
    input logic [1:0]         pending,
    input logic [LINE_AW-1:0] line_q,
    input logic               mem_we,
    input logic [LINE_AW-1:0] mem_addr
);

    // R5
    commit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // R4
    commit_needs_fourth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(data_wr && (pending == 2'd3)));

    // R6
    commit_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ((line_q == mem_addr + LINE_AW'(1)) && (pending == 2'd0)));

    // R3
    pending_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !addr_wr && (pending != 2'd3)) |=> (pending == $past(pending) + 2'd1));

    // R10
    addr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_wr |=> ((pending == 2'd0) && !mem_we));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_wr && !addr_wr) |=> ($stable(pending) && $stable(line_q) && !mem_we));

endmodule

bind vlw_line_writer vlw_line_writer_chk #(.LINE_AW(LINE_AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr_wr  (addr_wr),
    .data_wr  (data_wr),
    .pending  (pend_cnt),
    .line_q   (line_q),
    .mem_we   (mem_we),
    .mem_addr (mem_addr)
);

// File: tb/vlw_line_writer_test.sv
`timescale 1ns/1ps
module vlw_line_writer_test;

    localparam int unsigned LAW = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           bus_en = 1'b0;
    logic           bus_we = 1'b0;
    logic [1:0]     bus_sel = 2'd0;
    logic [31:0]    bus_wdata = 32'd0;
    logic [31:0]    bus_rdata;
    logic           mem_we;
    logic [LAW-1:0] mem_addr;
    logic [127:0]   mem_wdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // bench model
    logic [LAW-1:0] e_line = '0;
    int             e_pend = 0;
    logic [31:0]    e_w [3];
    int             commits = 0;

    always #2.5 clk = ~clk;

    vlw_line_writer #(.LINE_AW(LAW)) uut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [1:0] sel);
        logic [31:0] r;
        r = '0;
        if (sel == 2'd0) r[LAW+3:4] = e_line;
        else if (sel == 2'd2) r[1:0] = 2'(e_pend);
        return r;
    endfunction

    // one bus cycle, started at a falling edge; checks the memory port after the edge
    task automatic step(input logic en, input logic we, input logic [1:0] sel, input logic [31:0] d);
        logic           x_we;
        logic [LAW-1:0] x_addr;
        logic [127:0]   x_data;
        x_we = 1'b0; x_addr = '0; x_data = '0;
        bus_en = en; bus_we = we; bus_sel = sel; bus_wdata = d;
        if (en && !we) begin
            #1;
            chk(bus_rdata == exp_read(sel), (sel == 2'd2) ? "R3 status read" :
                (sel == 2'd0) ? "R2 address read" : "R9 empty read", 128'(bus_rdata), 128'(exp_read(sel)));
        end
        if (en && we && sel == 2'd0) begin
            e_line = d[LAW+3:4];
            e_pend = 0;
        end else if (en && we && sel == 2'd1) begin
            if (e_pend == 3) begin
                x_we = 1'b1; x_addr = e_line; x_data = {d, e_w[2], e_w[1], e_w[0]};
                e_line = e_line + LAW'(1);
                e_pend = 0;
                commits++;
            end else begin
                e_w[e_pend] = d;
                e_pend++;
            end
        end
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
        chk(mem_we == x_we, "R4 R5 write strobe", 128'(mem_we), 128'(x_we));
        if (x_we && mem_we) begin
            chk(mem_addr == x_addr, "R5 line address", 128'(mem_addr), 128'(x_addr));
            chk(mem_wdata == x_data, "R5 line data order", mem_wdata, x_data);
        end
    endtask

    task automatic rd(input logic [1:0] sel);
        step(1'b1, 1'b0, sel, 32'd0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired act=1 exp=0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        int c0;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(mem_we == 1'b0, "R1 reset strobe", 128'(mem_we), 128'(0));
        rst_n = 1'b1;
        @(negedge clk);
        rd(2'd0); rd(2'd2);

        // R2 low four bits dropped
        step(1, 1, 2'd0, 32'h0000_0035);
        rd(2'd0);
        // R3 counting, R4 holding
        for (int i = 0; i < 3; i++) begin
            step(1, 1, 2'd1, 32'hA000_0000 + i);
            rd(2'd2);
        end
        for (int i = 0; i < 20; i++) step(0, 0, 2'd0, 32'd0);
        rd(2'd2);
        // R5 commit, R6 advance
        step(1, 1, 2'd1, 32'hA000_0003);
        rd(2'd0); rd(2'd2);
        chk(commits == 1, "R5 commit count", 128'(commits), 128'(1));

        // R7 wrap from the last line
        step(1, 1, 2'd0, 32'h0000_00F0);
        for (int i = 0; i < 4; i++) step(1, 1, 2'd1, 32'hB000_0000 + i);
        rd(2'd0);
        chk(e_line == '0, "R7 model wrap", 128'(e_line), 128'(0));

        // R8 unbroken burst of twelve words
        c0 = commits;
        for (int i = 0; i < 12; i++) step(1, 1, 2'd1, 32'hC000_0000 + i);
        chk(commits - c0 == 3, "R8 burst commits", 128'(commits - c0), 128'(3));
        rd(2'd0);

        // R10 flush of a partial line, address write right after a commit
        step(1, 1, 2'd1, 32'hD000_0001);
        step(1, 1, 2'd1, 32'hD000_0002);
        step(1, 1, 2'd0, 32'h0000_0080);
        rd(2'd2);
        for (int i = 0; i < 4; i++) step(1, 1, 2'd1, 32'hE000_0000 + i);
        step(1, 1, 2'd0, 32'h0000_0020);
        rd(2'd0); rd(2'd2);

        // R9 status and spare writes ignored
        step(1, 1, 2'd1, 32'hF000_0000);
        step(1, 1, 2'd2, 32'hFFFF_FFFF);
        step(1, 1, 2'd3, 32'hFFFF_FFFF);
        rd(2'd2); rd(2'd0); rd(2'd1); rd(2'd3);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            int unsigned r;
            r = $urandom_range(0, 99);
            if (r < 60)      step(1, 1, 2'd1, $urandom);
            else if (r < 66) step(1, 1, 2'd0, $urandom);
            else if (r < 72) step(1, 1, 2'($urandom_range(2, 3)), $urandom);
            else if (r < 84) step(0, 0, 2'd0, 32'd0);
            else             rd(2'($urandom_range(0, 3)));
        end
        rd(2'd0); rd(2'd2);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule